// File: doc/BRIEF.md
# Backlight Current Fade Controller

This block produces the live 8-bit current codes for two backlight current sinks, called MAIN and SUB, and a drive gate for each sink. Software-visible target codes arrive as plain inputs. With fading switched off a new target is passed to the output on the next clock. With fading switched on, one selected channel walks toward its target one LSB at a time. Each step waits a programmed number of timebase ticks, so a full-scale change takes a fixed time and a partial change finishes in proportionally less time. The other channel follows its target at once.

A merge control lets the SUB sink reuse the MAIN code, so that a long LED string split over both sinks stays matched. Each gate combines the sink enable with an optional external PWM level that is active high. The timebase is a single-cycle `tick_i` strobe of roughly kilohertz rate. The `TICKS_SLOW` and `TICKS_FAST` parameters set how many ticks make one step. The defaults of 10 and 5 ticks at a 2 kHz strobe give about 1.28 s and 0.64 s for a full-scale change.

Top module: `bl_fade_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, both codes are 0 and `busy_o` is 0.
- R2: With `fade_en_i`=1, a fading channel moves by exactly one LSB per step, in both directions. A step lasts `TICKS_SLOW` ticks when `slope_fast_i`=0 and `TICKS_FAST` ticks when it is 1, so a full change from 0 to 255 takes 255 steps.
- R3: The step counter restarts while the fading channel is idle. The first LSB change after a new target is written therefore comes on exactly the N-th tick, and a change of d codes completes after d×N ticks.
- R4: `fade_sub_i`=0 selects MAIN for fading and `fade_sub_i`=1 selects SUB. The channel that is not selected takes its new target on the next clock.
- R5: When `merge_i`=1, `sub_code_o` equals `main_code_o` on every cycle. With `fade_sub_i`=0 this makes both outputs fade together.
- R6: A sink's gate is 0 whenever its enable input is 0.
- R7: When a sink's PWM select is 1, its gate follows `xpwm_i`, high meaning driven. When the select is 0, the gate equals the enable.
- R8: With `fade_en_i`=0, each code equals the target that was present at the previous clock edge.
- R9: A target written during a fade redirects the ramp from the current live code with no jump. The output keeps its value until the next step, then moves toward the new target.
- R10: `busy_o` is 1 exactly while fading is enabled and the fading channel's live code differs from its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Single-cycle timebase strobe |
| main_tgt_i | input | 8 | MAIN target code (0.1 mA per LSB) |
| sub_tgt_i | input | 8 | SUB target code |
| fade_en_i | input | 1 | 1 = ramp the selected channel |
| slope_fast_i | input | 1 | 1 = short step interval |
| fade_sub_i | input | 1 | 0 = fade MAIN, 1 = fade SUB |
| merge_i | input | 1 | 1 = SUB sink uses MAIN code |
| main_en_i | input | 1 | MAIN sink enable |
| sub_en_i | input | 1 | SUB sink enable |
| main_xpwm_sel_i | input | 1 | MAIN gated by external PWM |
| sub_xpwm_sel_i | input | 1 | SUB gated by external PWM |
| xpwm_i | input | 1 | Synchronized external PWM level |
| main_code_o | output | 8 | Live MAIN DAC code |
| sub_code_o | output | 8 | Live SUB DAC code |
| main_gate_o | output | 1 | MAIN sink drive |
| sub_gate_o | output | 1 | SUB sink drive |
| busy_o | output | 1 | Fade in progress |

## Verification
The case hardest to reach is the timing at the edge of each step. A code that changes one tick early or late looks correct if it is sampled only at the end of a ramp. For this reason, every step of both full-scale ramps is observed twice: one tick before the step is due, when the code must still hold its old value, and on the due tick itself. A redirect test writes a new target at a step boundary in the middle of a ramp. It then checks that the live code holds its value before the ramp reverses, so a jump to the new target cannot go unnoticed.

// File: rtl/bl_fade_pkg.sv
// Shared definitions for the backlight fade controller.
// Assumes exactly two sinks, indexed by the constants below.
package bl_fade_pkg;
    localparam int NUM_CH  = 2;
    localparam int CH_MAIN = 0;
    localparam int CH_SUB  = 1;

    // Pick the larger of two tick counts, used to size the step counter.
    function automatic int max_ticks(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/bl_step_timer.sv
// Step timer: counts timebase ticks and emits one step strobe every
// TICKS_SLOW or TICKS_FAST ticks while run_i is high.
// Assumes both tick counts are >= 1. The counter is held at zero while
// idle, so the first step after a restart lands on the N-th tick.
module bl_step_timer #(
    parameter int TICKS_SLOW = 10,
    parameter int TICKS_FAST = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic fast_i,
    input  logic run_i,
    output logic step_o
);
    localparam int MAXT  = bl_fade_pkg::max_ticks(TICKS_SLOW, TICKS_FAST);
    localparam int CNT_W = $clog2(MAXT + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;
    logic             wrap;

    // Terminal count for the selected slope.
    always_comb begin
        lim_m1 = fast_i ? CNT_W'(TICKS_FAST - 1) : CNT_W'(TICKS_SLOW - 1);
        wrap   = (cnt >= lim_m1);
        step_o = run_i && tick_i && wrap;
    end

    // Tick counter, cleared whenever no fade is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_i) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bl_code_ramp.sv
// One channel's live code register. It copies the target when not
// fading, and moves one LSB toward the target on each step when fading.
// Assumes step_i is a single-cycle strobe.
module bl_code_ramp #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tgt_i,
    input  logic              fading_i,
    input  logic              step_i,
    output logic [CODE_W-1:0] live_o,
    output logic              differ_o
);
    logic [CODE_W-1:0] live;

    // Live code update: copy, step up, step down or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else if (!fading_i) begin
            live <= tgt_i;
        end else if (step_i && (live < tgt_i)) begin
            live <= live + 1'b1;
        end else if (step_i && (live > tgt_i)) begin
            live <= live - 1'b1;
        end
    end

    assign live_o   = live;
    assign differ_o = (live != tgt_i);
endmodule

// File: rtl/bl_sink_gate.sv
// Drive gate for one sink: the enable, optionally qualified by the
// active-high external PWM level. Assumes pwm_i is already synchronized.
module bl_sink_gate (
    input  logic en_i,
    input  logic pwm_sel_i,
    input  logic pwm_i,
    output logic gate_o
);
    // Gate combine.
    assign gate_o = en_i && (!pwm_sel_i || pwm_i);
endmodule

// File: rtl/bl_fade_ctrl.sv
// Backlight fade controller top. It ramps the MAIN or SUB code toward its
// target at a programmed step rate, slaves SUB to MAIN in merge mode and
// gates each sink.
// Assumes tick_i is a one-cycle strobe and xpwm_i is synchronous to clk.
module bl_fade_ctrl #(
    parameter int CODE_W     = 8,
    parameter int TICKS_SLOW = 10,
    parameter int TICKS_FAST = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] main_tgt_i,
    input  logic [CODE_W-1:0] sub_tgt_i,
    input  logic              fade_en_i,
    input  logic              slope_fast_i,
    input  logic              fade_sub_i,
    input  logic              merge_i,
    input  logic              main_en_i,
    input  logic              sub_en_i,
    input  logic              main_xpwm_sel_i,
    input  logic              sub_xpwm_sel_i,
    input  logic              xpwm_i,
    output logic [CODE_W-1:0] main_code_o,
    output logic [CODE_W-1:0] sub_code_o,
    output logic              main_gate_o,
    output logic              sub_gate_o,
    output logic              busy_o
);
    import bl_fade_pkg::*;

    logic [CODE_W-1:0] tgt    [NUM_CH];
    logic [CODE_W-1:0] live   [NUM_CH];
    logic [NUM_CH-1:0] fading;
    logic [NUM_CH-1:0] differ;
    logic [NUM_CH-1:0] en;
    logic [NUM_CH-1:0] sel;
    logic [NUM_CH-1:0] gate;
    logic              step;

    // Per-channel targets and fade selection; a merged SUB is never faded.
    always_comb begin
        tgt[CH_MAIN]    = main_tgt_i;
        tgt[CH_SUB]     = merge_i ? main_tgt_i : sub_tgt_i;
        fading[CH_MAIN] = fade_en_i && !fade_sub_i;
        fading[CH_SUB]  = fade_en_i && fade_sub_i && !merge_i;
        en              = {sub_en_i, main_en_i};
        sel             = {sub_xpwm_sel_i, main_xpwm_sel_i};
    end

    assign busy_o = |(fading & differ);

    bl_step_timer #(
        .TICKS_SLOW(TICKS_SLOW),
        .TICKS_FAST(TICKS_FAST)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .fast_i (slope_fast_i),
        .run_i  (busy_o),
        .step_o (step)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        bl_code_ramp #(.CODE_W(CODE_W)) u_ramp (
            .clk      (clk),
            .rst_n    (rst_n),
            .tgt_i    (tgt[ch]),
            .fading_i (fading[ch]),
            .step_i   (step),
            .live_o   (live[ch]),
            .differ_o (differ[ch])
        );
        bl_sink_gate u_gate (
            .en_i      (en[ch]),
            .pwm_sel_i (sel[ch]),
            .pwm_i     (xpwm_i),
            .gate_o    (gate[ch])
        );
    end

    // Output selection: merge drives the SUB DAC from the MAIN code.
    always_comb begin
        main_code_o = live[CH_MAIN];
        sub_code_o  = merge_i ? live[CH_MAIN] : live[CH_SUB];
        main_gate_o = gate[CH_MAIN];
        sub_gate_o  = gate[CH_SUB];
    end
endmodule

// File: rtl/bl_fade_ctrl_chk.sv
// Port-level checker for bl_fade_ctrl, attached by bind.
module bl_fade_ctrl_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] main_tgt_i,
    input logic [CODE_W-1:0] sub_tgt_i,
    input logic              fade_en_i,
    input logic              fade_sub_i,
    input logic              merge_i,
    input logic              main_en_i,
    input logic              sub_en_i,
    input logic              main_xpwm_sel_i,
    input logic              xpwm_i,
    input logic [CODE_W-1:0] main_code_o,
    input logic [CODE_W-1:0] sub_code_o,
    input logic              main_gate_o,
    input logic              sub_gate_o,
    input logic              busy_o
);
    AST_MAIN_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (fade_en_i && !fade_sub_i && $past(fade_en_i && !fade_sub_i)) |->
        (main_code_o == $past(main_code_o) || main_code_o == $past(main_code_o) + 1'b1 ||
         main_code_o == $past(main_code_o) - 1'b1)); // R2
    AST_UNSEL_JUMPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fade_en_i && !fade_sub_i && !merge_i) |=> (merge_i || sub_code_o == $past(sub_tgt_i))); // R4
    AST_MERGE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        merge_i |-> (sub_code_o == main_code_o)); // R5
    AST_MAIN_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !main_en_i |-> !main_gate_o); // R6
    AST_SUB_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_en_i |-> !sub_gate_o); // R6
    AST_PWM_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (main_xpwm_sel_i && !xpwm_i) |-> !main_gate_o); // R7
    AST_NOFADE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        !fade_en_i |=> (main_code_o == $past(main_tgt_i))); // R8
    AST_BUSY_NEEDS_FADE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> fade_en_i); // R10
endmodule

bind bl_fade_ctrl bl_fade_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .main_tgt_i      (main_tgt_i),
    .sub_tgt_i       (sub_tgt_i),
    .fade_en_i       (fade_en_i),
    .fade_sub_i      (fade_sub_i),
    .merge_i         (merge_i),
    .main_en_i       (main_en_i),
    .sub_en_i        (sub_en_i),
    .main_xpwm_sel_i (main_xpwm_sel_i),
    .xpwm_i          (xpwm_i),
    .main_code_o     (main_code_o),
    .sub_code_o      (sub_code_o),
    .main_gate_o     (main_gate_o),
    .sub_gate_o      (sub_gate_o),
    .busy_o          (busy_o)
);

// File: tb/bl_fade_ctrl_tb.sv
module bl_fade_ctrl_tb;
    localparam int NS = 10;
    localparam int NF = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [7:0] main_tgt, sub_tgt;
    logic       fade_en, slope_fast, fade_sub, merge;
    logic       main_en, sub_en, main_sel, sub_sel, xpwm;
    logic [7:0] main_code, sub_code;
    logic       main_gate, sub_gate, busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bl_fade_ctrl #(.CODE_W(8), .TICKS_SLOW(NS), .TICKS_FAST(NF)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .main_tgt_i(main_tgt), .sub_tgt_i(sub_tgt),
        .fade_en_i(fade_en), .slope_fast_i(slope_fast), .fade_sub_i(fade_sub),
        .merge_i(merge), .main_en_i(main_en), .sub_en_i(sub_en),
        .main_xpwm_sel_i(main_sel), .sub_xpwm_sel_i(sub_sel), .xpwm_i(xpwm),
        .main_code_o(main_code), .sub_code_o(sub_code),
        .main_gate_o(main_gate), .sub_gate_o(sub_gate), .busy_o(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // Load MAIN live code to v without fading, then restore the fade enable.
    task automatic preset_main(input int v, input logic fe);
        fade_en  = 1'b0;
        main_tgt = 8'(v);
        @(negedge clk);
        fade_en = fe;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; main_tgt = 8'd33; sub_tgt = 8'd44;
        fade_en = 1'b0; slope_fast = 1'b0; fade_sub = 1'b0; merge = 1'b0;
        main_en = 1'b0; sub_en = 1'b0; main_sel = 1'b0; sub_sel = 1'b0; xpwm = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 main", main_code, 0);
        chk("R1 sub", sub_code, 0);
        chk("R1 busy", busy, 0);
        main_tgt = 8'd0; sub_tgt = 8'd0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 main after release", main_code, 0);

        // R8: exhaustive direct pass-through with fade off
        for (int v = 0; v < 256; v++) begin
            main_tgt = 8'(v);
            sub_tgt  = 8'(255 - v);
            @(negedge clk);
            chk("R8 main", main_code, v);
            chk("R8 sub", sub_code, 255 - v);
            chk("R10 idle busy", busy, 0);
        end

        // R2/R3: slow full-scale up ramp on MAIN, every step edge checked
        preset_main(0, 1'b1);
        slope_fast = 1'b0;
        main_tgt   = 8'd255;
        @(negedge clk);
        chk("R9 no jump at start", main_code, 0);
        chk("R10 busy start", busy, 1);
        for (int m = 1; m <= 255; m++) begin
            ticks(NS - 1);
            chk("R3 hold before step", main_code, m - 1);
            ticks(1);
            chk("R2 slow up step", main_code, m);
            chk("R10 busy during", busy, (m < 255) ? 1 : 0);
        end

        // R2: fast full-scale down ramp
        slope_fast = 1'b1;
        main_tgt   = 8'd0;
        @(negedge clk);
        for (int m = 254; m >= 0; m--) begin
            ticks(NF - 1);
            chk("R3 hold before fast step", main_code, m + 1);
            ticks(1);
            chk("R2 fast down step", main_code, m);
        end
        chk("R10 busy end", busy, 0);

        // R3: partial change of 40 codes takes 40*NF ticks
        main_tgt = 8'd40;
        @(negedge clk);
        ticks(40 * NF - 1);
        chk("R3 partial one tick early", main_code, 39);
        ticks(1);
        chk("R3 partial done", main_code, 40);
        chk("R3 partial busy", busy, 0);

        // R4: unselected SUB jumps during MAIN fade
        main_tgt = 8'd100;
        ticks(3 * NF);
        sub_tgt = 8'd77;
        @(negedge clk);
        chk("R4 sub jumps", sub_code, 77);
        chk("R4 main still ramping", main_code, 43);

        // R9: redirect at a step boundary, no jump, then reverse
        main_tgt = 8'd30;
        @(negedge clk);
        chk("R9 held on redirect", main_code, 43);
        ticks(NF);
        chk("R9 first reverse step", main_code, 42);
        ticks(12 * NF);
        chk("R9 reached new target", main_code, 30);
        chk("R9 busy clear", busy, 0);

        // R4: select SUB for fading, MAIN now jumps
        fade_sub = 1'b1;
        sub_tgt  = 8'd87;
        main_tgt = 8'd200;
        @(negedge clk);
        chk("R4 main jumps", main_code, 200);
        chk("R4 sub held", sub_code, 77);
        chk("R10 busy sub fade", busy, 1);
        ticks(10 * NF);
        chk("R4 sub faded", sub_code, 87);
        chk("R10 busy sub done", busy, 0);

        // R5: merge with MAIN fading moves both together
        fade_sub = 1'b0;
        merge    = 1'b1;
        preset_main(10, 1'b1);
        main_tgt = 8'd20;
        @(negedge clk);
        for (int m = 11; m <= 20; m++) begin
            ticks(NF);
            chk("R5 main merged", main_code, m);
            chk("R5 sub follows", sub_code, m);
        end
        merge = 1'b0;
        fade_en = 1'b0;
        @(negedge clk);

        // R6/R7: exhaustive gate combinations per sink
        for (int c = 0; c < 8; c++) begin
            main_en = c[0]; main_sel = c[1]; xpwm = c[2];
            sub_en = c[0]; sub_sel = ~c[1];
            @(negedge clk);
            chk("R6 R7 main gate", main_gate, c[0] & (~c[1] | c[2]));
            chk("R6 R7 sub gate", sub_gate, c[0] & (c[1] | c[2]));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule